// File: doc/BRIEF.md
# Multiply-Accumulate Accumulator Layout Converter

This block holds a set of wide multiply-accumulate accumulators together with the mode status word that governs their bit layout. Each accumulator is 48 bits wide. It carries a 32-bit main value, a low extension byte and a high extension byte. The high byte always occupies the top eight bits. Where the main value and the low byte sit depends on whether the status selects fractional or integer arithmetic. In integer mode, the signed/unsigned choice also decides how the high byte is filled.

Software or a neighbouring datapath writes accumulators through a valid/ready port and reads every accumulator at once from a flat output bus. A status write that flips the fractional bit or the signed bit makes the block repack every accumulator. Each field is first pulled out using the old layout, and the word is then rebuilt in the new one. The parameter `SERIAL` selects how the repack runs. With `SERIAL=0`, all accumulators are repacked on the edge that accepts the write. With `SERIAL=1`, one accumulator is repacked per cycle while `busy` is high. Back-pressure is applied by dropping ready. The upstream side holds its valid signal and payload steady until the cycle in which valid and ready are both high, which is when the transfer takes place.

Top module: `mac_acc_repack`

## Requirements
- R1: After reset, `stat_q` is zero (integer, unsigned), every accumulator on `acc_q` is zero and `busy` is low.
- R2: An accumulator write is accepted on a clock edge where `acc_wr_valid` and `acc_wr_ready` are both high. It stores `acc_wr_data` unchanged into accumulator `acc_wr_idx`, which appears on `acc_q[idx*48 +: 48]` after that edge.
- R3: A status write is accepted on a clock edge where `stat_wr_valid` and `stat_wr_ready` are both high. If it leaves bit 1 (fractional) and bit 0 (signed) unchanged, it only updates `stat_q`, leaves every accumulator unchanged and does not raise `busy`.
- R4: A repack reads each accumulator using the old mode. In fractional mode the main value is bits 39..8 and the low byte is bits 7..0. In integer mode the main value is bits 31..0 and the low byte is bits 39..32. In both modes the high byte is bits 47..40.
- R5: When the new mode is fractional, the repacked word is {high, main, low}, with the main value in bits 39..8.
- R6: When the new mode is unsigned integer, the repacked word is {high, low, main}, with the high byte copied unchanged.
- R7: When the new mode is signed integer, the repacked word is {high, low, main}. If bit 7 of the low byte is set, bits 47..40 become all ones.
- R8: With `SERIAL=1`, `busy` is high for exactly NUM_ACC cycles after the edge that accepts a mode-changing write, and `stat_q` keeps its old value until the last repack step. With `SERIAL=0`, the repack and the new `stat_q` take effect on the accepting edge and `busy` stays low.
- R9: While `busy` is high, `stat_wr_ready` and `acc_wr_ready` are both low.
- R10: While `stat_wr_valid` is high, `acc_wr_ready` is low, so a status write always goes before an accumulator write offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_wr_valid | input | 1 | Status write offered |
| stat_wr_ready | output | 1 | Status write can be taken |
| stat_wr_data | input | STAT_W | New status value (bit 1 fractional, bit 0 signed) |
| stat_q | output | STAT_W | Current status value |
| busy | output | 1 | Serial repack in progress |
| acc_wr_valid | input | 1 | Accumulator write offered |
| acc_wr_ready | output | 1 | Accumulator write can be taken |
| acc_wr_idx | input | IDX_W | Target accumulator |
| acc_wr_data | input | ACC_W | Packed value to store |
| acc_q | output | NUM_ACC*ACC_W | All accumulators, index 0 in the low bits |

## Verification
A status write and an accumulator write can be offered in the same cycle, and the outcome depends on which one is taken first. The bench creates this collision by raising both valids on one negative edge with a mode change pending. It expects `acc_wr_ready` to be low in that cycle. It holds the accumulator write until the repack has finished, and then expects the written accumulator to hold its raw data while the others show the new layout. A serial and a parallel instance share the same stimulus, and for every ordered pair of distinct modes both are checked against layouts computed arithmetically in the bench.

// File: rtl/mac_repack_pkg.sv
package mac_repack_pkg;
  localparam int FRAC_POS = 1;
  localparam int SIGN_POS = 0;

  typedef struct packed {
    logic frac;
    logic sgn;
  } mac_mode_t;
endpackage

// File: rtl/mac_repack_lane.sv
module mac_repack_lane
  import mac_repack_pkg::*;
#(
  parameter int MAIN_W = 32,
  parameter int EXT_W  = 8,
  localparam int ACC_W = MAIN_W + 2 * EXT_W
) (
  input  logic [ACC_W-1:0] word_in,
  input  mac_mode_t        old_mode,
  input  mac_mode_t        new_mode,
  output logic [ACC_W-1:0] word_out
);
  logic [MAIN_W-1:0] main_v;
  logic [EXT_W-1:0]  low_v;
  logic [EXT_W-1:0]  high_v;
  logic [EXT_W-1:0]  high_fill;

  always_comb begin
    high_v = word_in[ACC_W-1 -: EXT_W];
    if (old_mode.frac) begin
      main_v = word_in[EXT_W +: MAIN_W];
      low_v  = word_in[0 +: EXT_W];
    end else begin
      main_v = word_in[0 +: MAIN_W];
      low_v  = word_in[MAIN_W +: EXT_W];
    end
    high_fill = {EXT_W{new_mode.sgn & low_v[EXT_W-1]}};
    if (new_mode.frac) begin
      word_out = {high_v, main_v, low_v};
    end else begin
      word_out = {high_v | high_fill, low_v, main_v};
    end
  end

  // R7: signed integer layout with a negative low byte fills the high byte
  always_comb begin
    if (!new_mode.frac && new_mode.sgn && low_v[EXT_W-1]) begin
      p_sign_fill_r7: assert (word_out[ACC_W-1 -: EXT_W] == {EXT_W{1'b1}});
    end
  end
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank #(
  parameter int NUM_ACC = 4,
  parameter int ACC_W   = 48
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_ACC-1:0]         we,
  input  logic [NUM_ACC*ACC_W-1:0]   wdata,
  output logic [NUM_ACC*ACC_W-1:0]   acc_q
);
  for (genvar g = 0; g < NUM_ACC; g++) begin : g_slot
    logic [ACC_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (we[g]) begin
        slot_q <= wdata[g*ACC_W +: ACC_W];
      end
    end
    assign acc_q[g*ACC_W +: ACC_W] = slot_q;
  end

  // R3: no write enable, no change in any accumulator
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we == '0) |=> $stable(acc_q));
endmodule

// File: rtl/mac_repack_ctl.sv
module mac_repack_ctl
  import mac_repack_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int STAT_W  = 8,
  parameter bit SERIAL  = 1'b1,
  localparam int IDX_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stat_wr_valid,
  output logic               stat_wr_ready,
  input  logic [STAT_W-1:0]  stat_wr_data,
  output logic [STAT_W-1:0]  stat_q,
  output logic               busy,
  output mac_mode_t          old_mode,
  output mac_mode_t          new_mode,
  output logic [NUM_ACC-1:0] step_en
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ACC - 1);

  logic      fire;
  logic      change;
  mac_mode_t wr_mode;
  mac_mode_t cur_mode;

  assign wr_mode.frac  = stat_wr_data[FRAC_POS];
  assign wr_mode.sgn   = stat_wr_data[SIGN_POS];
  assign cur_mode.frac = stat_q[FRAC_POS];
  assign cur_mode.sgn  = stat_q[SIGN_POS];
  assign stat_wr_ready = !busy;
  assign fire          = stat_wr_valid && stat_wr_ready;
  assign change        = fire && (wr_mode != cur_mode);
  assign old_mode      = cur_mode;

  if (SERIAL) begin : g_serial
    logic [STAT_W-1:0] pend_q;
    logic [IDX_W-1:0]  idx_q;
    logic              busy_q;
    mac_mode_t         pend_mode;

    assign pend_mode.frac = pend_q[FRAC_POS];
    assign pend_mode.sgn  = pend_q[SIGN_POS];
    assign new_mode       = pend_mode;
    assign busy           = busy_q;

    always_comb begin
      step_en = '0;
      if (busy_q) step_en[idx_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat_q <= '0;
        pend_q <= '0;
        idx_q  <= '0;
        busy_q <= 1'b0;
      end else if (fire) begin
        if (change) begin
          pend_q <= stat_wr_data;
          idx_q  <= '0;
          busy_q <= 1'b1;
        end else begin
          stat_q <= stat_wr_data;
        end
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          stat_q <= pend_q;
        end
      end
    end

    // R8: status holds its old value through every step but the last
    p_stat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && idx_q != LAST) |=> $stable(stat_q));
    // R8: busy ends only after the last accumulator was stepped
    p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> ($past(idx_q) == LAST));
  end else begin : g_parallel
    assign new_mode = wr_mode;
    assign busy     = 1'b0;
    assign step_en  = {NUM_ACC{change}};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat_q <= '0;
      end else if (fire) begin
        stat_q <= stat_wr_data;
      end
    end

    // R8: parallel variant updates status on the accepting edge
    p_par_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (stat_q == $past(stat_wr_data)));
  end
endmodule

// File: rtl/mac_acc_repack.sv
module mac_acc_repack
  import mac_repack_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int MAIN_W  = 32,
  parameter int EXT_W   = 8,
  parameter int STAT_W  = 8,
  parameter bit SERIAL  = 1'b1,
  localparam int ACC_W  = MAIN_W + 2 * EXT_W,
  localparam int IDX_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stat_wr_valid,
  output logic                     stat_wr_ready,
  input  logic [STAT_W-1:0]        stat_wr_data,
  output logic [STAT_W-1:0]        stat_q,
  output logic                     busy,
  input  logic                     acc_wr_valid,
  output logic                     acc_wr_ready,
  input  logic [IDX_W-1:0]         acc_wr_idx,
  input  logic [ACC_W-1:0]         acc_wr_data,
  output logic [NUM_ACC*ACC_W-1:0] acc_q
);
  mac_mode_t            old_mode;
  mac_mode_t            new_mode;
  logic [NUM_ACC-1:0]   step_en;
  logic [NUM_ACC-1:0]   we;
  logic [NUM_ACC*ACC_W-1:0] wdata;
  logic                 acc_fire;

  mac_repack_ctl #(
    .NUM_ACC (NUM_ACC),
    .STAT_W  (STAT_W),
    .SERIAL  (SERIAL)
  ) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .stat_wr_valid (stat_wr_valid),
    .stat_wr_ready (stat_wr_ready),
    .stat_wr_data  (stat_wr_data),
    .stat_q        (stat_q),
    .busy          (busy),
    .old_mode      (old_mode),
    .new_mode      (new_mode),
    .step_en       (step_en)
  );

  assign acc_wr_ready = !busy && !stat_wr_valid;
  assign acc_fire     = acc_wr_valid && acc_wr_ready;

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_lane
    logic [ACC_W-1:0] repacked;
    logic             host_hit;

    mac_repack_lane #(
      .MAIN_W (MAIN_W),
      .EXT_W  (EXT_W)
    ) u_lane (
      .word_in  (acc_q[g*ACC_W +: ACC_W]),
      .old_mode (old_mode),
      .new_mode (new_mode),
      .word_out (repacked)
    );

    assign host_hit = acc_fire && (acc_wr_idx == IDX_W'(g));
    assign we[g]    = host_hit || step_en[g];
    assign wdata[g*ACC_W +: ACC_W] = host_hit ? acc_wr_data : repacked;
  end

  mac_acc_bank #(
    .NUM_ACC (NUM_ACC),
    .ACC_W   (ACC_W)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .wdata (wdata),
    .acc_q (acc_q)
  );

  // R10: a pending status write holds accumulator writes back
  p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_valid |-> !acc_wr_ready);
  // R9: no accumulator write lands while a repack is running
  p_busy_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !acc_fire);
  // R2: an accepted write shows its data unchanged on the next cycle
  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (acc_q[$past(acc_wr_idx)*ACC_W +: ACC_W] == $past(acc_wr_data)));
endmodule

// File: tb/test_mac_acc_repack.sv
module test_mac_acc_repack;
  localparam int CLK_PERIOD = 10;
  localparam int NACC = 4;
  localparam int AW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stat_wr_valid = 1'b0;
  logic [7:0] stat_wr_data = '0;
  logic acc_wr_valid = 1'b0;
  logic [1:0] acc_wr_idx = '0;
  logic [AW-1:0] acc_wr_data = '0;

  logic s_stat_rdy, s_busy, s_acc_rdy;
  logic [7:0] s_stat;
  logic [NACC*AW-1:0] s_acc;
  logic p_stat_rdy, p_busy, p_acc_rdy;
  logic [7:0] p_stat;
  logic [NACC*AW-1:0] p_acc;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_acc_repack #(.SERIAL(1'b1)) i_mac_acc_repack (
    .clk(clk), .rst_n(rst_n),
    .stat_wr_valid(stat_wr_valid), .stat_wr_ready(s_stat_rdy),
    .stat_wr_data(stat_wr_data), .stat_q(s_stat), .busy(s_busy),
    .acc_wr_valid(acc_wr_valid), .acc_wr_ready(s_acc_rdy),
    .acc_wr_idx(acc_wr_idx), .acc_wr_data(acc_wr_data), .acc_q(s_acc));

  mac_acc_repack #(.SERIAL(1'b0)) i_mac_acc_repack_par (
    .clk(clk), .rst_n(rst_n),
    .stat_wr_valid(stat_wr_valid), .stat_wr_ready(p_stat_rdy),
    .stat_wr_data(stat_wr_data), .stat_q(p_stat), .busy(p_busy),
    .acc_wr_valid(acc_wr_valid), .acc_wr_ready(p_acc_rdy),
    .acc_wr_idx(acc_wr_idx), .acc_wr_data(acc_wr_data), .acc_q(p_acc));

  task automatic check(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] expect_word(input logic [AW-1:0] w,
      input bit ofr, input bit nfr, input bit nsg);
    logic [31:0] m;
    logic [7:0] lo, hi;
    hi = w[47:40];
    m  = ofr ? 32'((w / 256) % 48'h1_0000_0000) : w[31:0];
    lo = ofr ? w[7:0] : 8'((w / 48'h1_0000_0000) % 256);
    if (nfr) return {hi, m, lo};
    if (nsg && lo >= 8'd128) hi = 8'hFF;
    return {hi, lo, m};
  endfunction

  task automatic put_stat(input logic [7:0] d, output int busy_cycles);
    @(negedge clk);
    while (s_busy) @(negedge clk);
    stat_wr_valid = 1'b1;
    stat_wr_data = d;
    @(negedge clk);
    stat_wr_valid = 1'b0;
    busy_cycles = 0;
    while (s_busy) begin
      busy_cycles++;
      if (s_stat_rdy || s_acc_rdy) check("R9", "ready while busy", 48'(1), 48'(0));
      @(negedge clk);
    end
  endtask

  task automatic put_acc(input int idx, input logic [AW-1:0] d);
    @(negedge clk);
    while (s_busy) @(negedge clk);
    acc_wr_valid = 1'b1;
    acc_wr_idx = 2'(idx);
    acc_wr_data = d;
    @(negedge clk);
    acc_wr_valid = 1'b0;
  endtask

  initial begin
    int bc;
    logic [AW-1:0] pat [NACC];
    logic [AW-1:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "status", 48'(s_stat), 48'(0));
    check("R1", "busy", 48'(s_busy), 48'(0));
    for (int i = 0; i < NACC; i++) begin
      check("R1", "serial acc", s_acc[i*AW +: AW], '0);
      check("R1", "parallel acc", p_acc[i*AW +: AW], '0);
    end

    for (int om = 0; om < 4; om++) begin
      for (int nm = 0; nm < 4; nm++) begin
        if (om == nm) continue;
        put_stat(8'(om), bc);
        pat[0] = 48'h80_1234_5678_9A;
        pat[1] = 48'h7F_8000_0001_FF;
        pat[2] = 48'h00_FFFF_FFFF_7F;
        pat[3] = 48'hC3_0F0F_0F0F_80 ^ 48'(om * 16 + nm);
        for (int i = 0; i < NACC; i++) put_acc(i, pat[i]);
        @(negedge clk);
        for (int i = 0; i < NACC; i++) begin
          check("R2", "serial readback", s_acc[i*AW +: AW], pat[i]);
          check("R2", "parallel readback", p_acc[i*AW +: AW], pat[i]);
        end
        @(negedge clk);
        stat_wr_valid = 1'b1;
        stat_wr_data = 8'(nm) | 8'hA4;
        @(negedge clk);
        stat_wr_valid = 1'b0;
        check("R8", "serial status still old", 48'(s_stat), 48'(om));
        check("R8", "parallel status new", 48'(p_stat), 48'(8'(nm) | 8'hA4));
        check("R8", "parallel busy", 48'(p_busy), 48'(0));
        bc = 0;
        while (s_busy) begin
          bc++;
          if (s_stat_rdy || s_acc_rdy) check("R9", "ready while busy", 48'(1), 48'(0));
          @(negedge clk);
        end
        check("R8", "busy length", 48'(bc), 48'(NACC));
        check("R8", "serial status after", 48'(s_stat), 48'(8'(nm) | 8'hA4));
        for (int i = 0; i < NACC; i++) begin
          e = expect_word(pat[i], om[1], nm[1], nm[0]);
          // R4 extraction, R5 fractional, R6 unsigned, R7 signed layouts
          check(nm[1] ? "R4/R5" : (nm[0] ? "R4/R7" : "R4/R6"),
                "serial repack", s_acc[i*AW +: AW], e);
          check(nm[1] ? "R4/R5" : (nm[0] ? "R4/R7" : "R4/R6"),
                "parallel repack", p_acc[i*AW +: AW], e);
        end
      end
    end

    // R3: status write keeping bits 1:0 leaves accumulators alone
    for (int i = 0; i < NACC; i++) pat[i] = s_acc[i*AW +: AW];
    put_stat((s_stat & 8'h03) | 8'h58, bc);
    check("R3", "no busy", 48'(bc), 48'(0));
    check("R3", "status updated", 48'(s_stat), 48'((s_stat & 8'h03) | 8'h58));
    for (int i = 0; i < NACC; i++) begin
      check("R3", "serial unchanged", s_acc[i*AW +: AW], pat[i]);
      check("R3", "parallel unchanged", p_acc[i*AW +: AW], pat[i]);
    end

    // R10: status and accumulator writes offered together
    put_stat(8'h00, bc);
    for (int i = 0; i < NACC; i++) put_acc(i, 48'h11_2233_4455_E6 + 48'(i));
    @(negedge clk);
    stat_wr_valid = 1'b1;
    stat_wr_data = 8'h01;
    acc_wr_valid = 1'b1;
    acc_wr_idx = 2'd2;
    acc_wr_data = 48'hDE_ADBE_EF01_23;
    #1;
    check("R10", "serial acc ready", 48'(s_acc_rdy), 48'(0));
    check("R10", "parallel acc ready", 48'(p_acc_rdy), 48'(0));
    @(negedge clk);
    stat_wr_valid = 1'b0;
    while (s_busy) @(negedge clk);
    @(negedge clk);
    acc_wr_valid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NACC; i++) begin
      e = (i == 2) ? 48'hDE_ADBE_EF01_23
                   : expect_word(48'h11_2233_4455_E6 + 48'(i), 1'b0, 1'b0, 1'b1);
      check("R10", "serial after collision", s_acc[i*AW +: AW], e);
      check("R10", "parallel after collision", p_acc[i*AW +: AW], e);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule